// File: doc/BRIEF.md
# Page Access Permission and Fault-Code Unit

This unit sits at the end of a page-table walk. The walker passes in the protection bits it collected at each level, whether each level was actually visited, the kind of access being translated, the privilege of the requester and the paging control flags. The unit merges the bits into one set of effective rights, decides whether the access may proceed, and produces one of two results. On success it gives the rights to install in a translation cache entry. On failure it gives the encoded page-fault error code. Walking memory and writing back accessed or dirty flags stay in the walker.

User and writable permissions tighten as the walk goes down: every visited level must grant them. Execute-disable works the other way: one visited level that sets it is enough. Write permission is held back from the cached rights until the leaf entry is dirty, so the first store still traps and the walker can set the dirty flag. The result is registered and appears one clock after the request is presented.

Top module: `pgperm_unit`

## Requirements
- R1: Across the levels whose `lvl_valid` bit is set, the effective user bit is the AND of `lvl_user` and the effective writable bit is the AND of `lvl_rw`. The effective execute-disable is the OR of `lvl_xd`. Levels whose valid bit is clear do not contribute.
- R2: When `top_open` is high, level 0 (the top level) counts as user-allowed, writable and executable, whatever its bits are.
- R3: When `nx_en` is high, a fetch (`access` = 2) to a page with effective execute-disable is a protection fault. When `nx_en` is low, the execute-disable bits have no effect.
- R4: A user access (`is_user` = 1) faults when the effective user bit is clear. A user write (`access` = 1) also faults when the effective writable bit is clear.
- R5: A supervisor write to a page whose effective writable bit is clear faults only when `wp_en` is high. Reads (`access` = 0) and fetches never fault on the writable bit.
- R6: On an allowed access, rights bit 0 (read) is always set, and rights bit 2 (execute) is set exactly when the effective execute-disable (as gated by `nx_en`) is clear.
- R7: Rights bit 1 (write) is set only when `leaf_dirty` is high and either the requester is a user with the effective writable bit set, or the requester is a supervisor with `wp_en` low or the effective writable bit set.
- R8: Error code bit 0 is set for protection faults and clear for not-present faults (`walk_fault` = 1). Bit 1 is set when the access is a write, and bit 2 is set when `is_user` is high.
- R9: A reserved-bit walk fault (`walk_fault` = 2) sets error bit 3 and leaves bit 0 clear. The other error bits follow R8 and R10.
- R10: Error bit 4 is set only for a faulting fetch while both `nx_en` and `ext_en` are high.
- R11: Any nonzero `walk_fault` produces a fault whatever the permissions are. A faulting result carries rights 0, and an allowed result carries error code 0.
- R12: Results appear exactly one clock after `in_valid`. During reset, and in cycles without a request, `out_valid`, `allow`, `fault`, `rights` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| lvl_valid | input | LEVELS | Level was visited by the walk (bit 0 = top) |
| lvl_user | input | LEVELS | Per-level user-allowed bit |
| lvl_rw | input | LEVELS | Per-level writable bit |
| lvl_xd | input | LEVELS | Per-level execute-disable bit |
| access | input | 2 | 0 read, 1 write, 2 fetch |
| is_user | input | 1 | Requester runs at user privilege |
| wp_en | input | 1 | Supervisor write-protect control |
| nx_en | input | 1 | No-execute enable |
| ext_en | input | 1 | Extended translation mode active |
| top_open | input | 1 | Top level imposes no restriction |
| leaf_dirty | input | 1 | Leaf entry dirty flag |
| walk_fault | input | 2 | 0 none, 1 not present, 2 reserved bit |
| out_valid | output | 1 | Result valid |
| allow | output | 1 | Access permitted |
| fault | output | 1 | Access faults |
| rights | output | 3 | Bit 0 read, bit 1 write, bit 2 execute |
| err_code | output | 5 | Fault error code |

## Verification
An error in how the per-level bits are merged, for example a level that is wrongly masked or an AND where an OR belongs, shows up one cycle later. Depending on the access, it appears as a flipped `allow`/`fault` pair or as a missing or extra execute or write right. Because of this, the corner vectors put a single restricting bit at each level in turn. A bad error-code assembly shows as a wrong bit in `err_code` on the same one-cycle result. The random vectors sweep every combination of privilege, access kind and mode flag against the bench's own model.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      WF_NONE   = 2'd0,
      WF_ABSENT = 2'd1,
      WF_RSVD   = 2'd2
   } wf_e;

   localparam int EC_W       = 5;
   localparam int EC_PRESENT = 0;
   localparam int EC_WRITE   = 1;
   localparam int EC_USER    = 2;
   localparam int EC_RSVD    = 3;
   localparam int EC_FETCH   = 4;

   localparam int RT_W     = 3;
   localparam int RT_READ  = 0;
   localparam int RT_WRITE = 1;
   localparam int RT_EXEC  = 2;

   typedef struct packed {
      logic user_ok;
      logic wr_ok;
      logic xd;
   } eff_t;

endpackage

// File: rtl/pgperm_merge.sv
module pgperm_merge
   import pgperm_pkg::*;
#(
   parameter int LEVELS = 4
) (
   input  logic [LEVELS-1:0] lvl_valid,
   input  logic [LEVELS-1:0] lvl_user,
   input  logic [LEVELS-1:0] lvl_rw,
   input  logic [LEVELS-1:0] lvl_xd,
   input  logic              top_open,
   input  logic              nx_en,
   output eff_t              eff
);
   logic [LEVELS-1:0] u_m, w_m, x_m;

   for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
      if (i == 0) begin : g_top
         // the top level may be declared unrestricted
         assign u_m[i] = !lvl_valid[i] | top_open | lvl_user[i];
         assign w_m[i] = !lvl_valid[i] | top_open | lvl_rw[i];
         assign x_m[i] = lvl_valid[i] & !top_open & lvl_xd[i];
      end else begin : g_low
         assign u_m[i] = !lvl_valid[i] | lvl_user[i];
         assign w_m[i] = !lvl_valid[i] | lvl_rw[i];
         assign x_m[i] = lvl_valid[i] & lvl_xd[i];
      end
   end

   always_comb begin
      eff.user_ok = &u_m;
      eff.wr_ok   = &w_m;
      eff.xd      = nx_en & (|x_m);
   end
endmodule

// File: rtl/pgperm_decide.sv
module pgperm_decide
   import pgperm_pkg::*;
(
   input  eff_t             eff,
   input  acc_e             acc,
   input  logic             is_user,
   input  logic             wp_en,
   input  logic             leaf_dirty,
   output logic             prot_fault,
   output logic [RT_W-1:0]  rights
);
   logic is_wr, is_fetch, wr_needs_rw;

   always_comb begin
      is_wr       = (acc == ACC_WRITE);
      is_fetch    = (acc == ACC_FETCH);
      // supervisors honour the writable bit only under write-protect
      wr_needs_rw = is_user | wp_en;

      prot_fault = 1'b0;
      if (is_fetch && eff.xd)                       prot_fault = 1'b1;
      if (is_user && !eff.user_ok)                  prot_fault = 1'b1;
      if (is_wr && wr_needs_rw && !eff.wr_ok)       prot_fault = 1'b1;

      rights           = '0;
      rights[RT_READ]  = 1'b1;
      rights[RT_EXEC]  = !eff.xd;
      rights[RT_WRITE] = leaf_dirty & (eff.wr_ok | !wr_needs_rw);
   end
endmodule

// File: rtl/pgperm_fault_enc.sv
module pgperm_fault_enc
   import pgperm_pkg::*;
(
   input  wf_e              walk_fault,
   input  logic             prot_fault,
   input  acc_e             acc,
   input  logic             is_user,
   input  logic             nx_en,
   input  logic             ext_en,
   output logic             any_fault,
   output logic [EC_W-1:0]  code
);
   logic walk_hit;

   always_comb begin
      walk_hit  = (walk_fault != WF_NONE);
      any_fault = walk_hit | prot_fault;
      code      = '0;
      if (any_fault) begin
         code[EC_PRESENT] = !walk_hit;
         code[EC_RSVD]    = (walk_fault == WF_RSVD);
         code[EC_WRITE]   = (acc == ACC_WRITE);
         code[EC_USER]    = is_user;
         code[EC_FETCH]   = (acc == ACC_FETCH) & nx_en & ext_en;
      end
   end
endmodule

// File: rtl/pgperm_unit.sv
module pgperm_unit
   import pgperm_pkg::*;
#(
   parameter int LEVELS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [LEVELS-1:0] lvl_valid,
   input  logic [LEVELS-1:0] lvl_user,
   input  logic [LEVELS-1:0] lvl_rw,
   input  logic [LEVELS-1:0] lvl_xd,
   input  logic [1:0]        access,
   input  logic              is_user,
   input  logic              wp_en,
   input  logic              nx_en,
   input  logic              ext_en,
   input  logic              top_open,
   input  logic              leaf_dirty,
   input  logic [1:0]        walk_fault,
   output logic              out_valid,
   output logic              allow,
   output logic              fault,
   output logic [2:0]        rights,
   output logic [4:0]        err_code
);
   if (LEVELS < 1 || LEVELS > 8) begin : g_bad_levels
      $error("pgperm_unit: LEVELS must lie in 1..8");
   end

   eff_t             eff;
   logic             prot_fault, any_fault;
   logic [RT_W-1:0]  rt_c;
   logic [EC_W-1:0]  ec_c;
   acc_e             acc_c;
   wf_e              wf_c;

   assign acc_c = acc_e'(access);
   assign wf_c  = wf_e'(walk_fault);

   pgperm_merge #(.LEVELS(LEVELS)) u_merge (
      .lvl_valid (lvl_valid),
      .lvl_user  (lvl_user),
      .lvl_rw    (lvl_rw),
      .lvl_xd    (lvl_xd),
      .top_open  (top_open),
      .nx_en     (nx_en),
      .eff       (eff)
   );

   pgperm_decide u_decide (
      .eff        (eff),
      .acc        (acc_c),
      .is_user    (is_user),
      .wp_en      (wp_en),
      .leaf_dirty (leaf_dirty),
      .prot_fault (prot_fault),
      .rights     (rt_c)
   );

   pgperm_fault_enc u_enc (
      .walk_fault (wf_c),
      .prot_fault (prot_fault),
      .acc        (acc_c),
      .is_user    (is_user),
      .nx_en      (nx_en),
      .ext_en     (ext_en),
      .any_fault  (any_fault),
      .code       (ec_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || !in_valid) begin
         out_valid <= 1'b0;
         allow     <= 1'b0;
         fault     <= 1'b0;
         rights    <= '0;
         err_code  <= '0;
      end else begin
         out_valid <= 1'b1;
         allow     <= !any_fault;
         fault     <= any_fault;
         rights    <= any_fault ? '0 : rt_c;
         err_code  <= ec_c;
      end
   end
endmodule

// File: rtl/pgperm_checker.sv
module pgperm_checker #(
   parameter int LEVELS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [LEVELS-1:0] lvl_valid,
   input logic [LEVELS-1:0] lvl_user,
   input logic [LEVELS-1:0] lvl_rw,
   input logic [LEVELS-1:0] lvl_xd,
   input logic [1:0]        access,
   input logic              is_user,
   input logic              wp_en,
   input logic              nx_en,
   input logic              ext_en,
   input logic              top_open,
   input logic              leaf_dirty,
   input logic [1:0]        walk_fault,
   input logic              out_valid,
   input logic              allow,
   input logic              fault,
   input logic [2:0]        rights,
   input logic [4:0]        err_code
);
   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !allow && !fault));

   assert_allow_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> (rights[0] && err_code == 5'd0 && !fault));

   assert_fault_no_rights_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (rights == 3'd0 && !allow));

   assert_absent_clear_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && walk_fault == 2'd1) |=> (fault && !err_code[0] && !err_code[3]));

   assert_rsvd_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && walk_fault == 2'd2) |=> (fault && err_code[3] && !err_code[0]));

   assert_write_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && access == 2'd1) |=> (!fault || err_code[1]));

   assert_sup_nowp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && walk_fault == 2'd0 && !is_user && !wp_en && access != 2'd2)
      |=> allow);

   assert_fetch_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(access == 2'd2 && nx_en && ext_en)) |=> !err_code[4]);
endmodule

bind pgperm_unit pgperm_checker #(.LEVELS(LEVELS)) u_pgperm_checker (.*);

// File: tb/test_pgperm_unit.sv
module test_pgperm_unit;
   localparam int L = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [L-1:0] lvl_valid, lvl_user, lvl_rw, lvl_xd;
   logic [1:0]   access, walk_fault;
   logic         is_user, wp_en, nx_en, ext_en, top_open, leaf_dirty;
   logic         out_valid, allow, fault;
   logic [2:0]   rights;
   logic [4:0]   err_code;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   pgperm_unit #(.LEVELS(L)) i_pgperm_unit (.*);

   // expected {out_valid, allow, fault, rights[2:0], err_code[4:0]}
   function automatic logic [10:0] model();
      logic u = 1'b1, w = 1'b1, x = 1'b0, pf = 1'b0, flt, wneed;
      logic [2:0] rt;
      logic [4:0] ec = '0;
      for (int i = 0; i < L; i++) begin
         if (lvl_valid[i] && !(i == 0 && top_open)) begin
            u &= lvl_user[i];
            w &= lvl_rw[i];
            x |= lvl_xd[i];
         end
      end
      x     = x & nx_en;
      wneed = is_user | wp_en;
      if (access == 2'd2 && x) pf = 1'b1;
      if (is_user && !u) pf = 1'b1;
      if (access == 2'd1 && wneed && !w) pf = 1'b1;
      flt = pf || walk_fault != 2'd0;
      rt  = flt ? 3'b000 : {!x, leaf_dirty & (w | !wneed), 1'b1};
      if (flt) begin
         ec[0] = (walk_fault == 2'd0);
         ec[1] = (access == 2'd1);
         ec[2] = is_user;
         ec[3] = (walk_fault == 2'd2);
         ec[4] = (access == 2'd2) && nx_en && ext_en;
      end
      return {1'b1, !flt, flt, rt, ec};
   endfunction

   task automatic check(input string tag, input logic [10:0] exp);
      logic [10:0] act;
      act = {out_valid, allow, fault, rights, err_code};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      in_valid = 0; lvl_valid = '1; lvl_user = '1; lvl_rw = '1; lvl_xd = '0;
      access = 2'd0; walk_fault = 2'd0; is_user = 0; wp_en = 0; nx_en = 0;
      ext_en = 0; top_open = 0; leaf_dirty = 1;
   endtask

   // caller has set the inputs; present them, then sample after the edge
   task automatic run(input string tag);
      logic [10:0] exp;
      @(negedge clk);
      in_valid = 1;
      exp = model();
      @(posedge clk);
      #5;
      check(tag, exp);
      in_valid = 0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle_inputs();
      rst_n = 0;
      in_valid = 1;
      repeat (3) @(posedge clk);
      #5;
      check("R12 reset", 11'd0);
      @(negedge clk);
      rst_n = 1;
      in_valid = 0;
      @(posedge clk); #5;
      check("R12 idle", 11'd0);

      // R1: one restricting user bit at each level in turn
      for (int i = 0; i < L; i++) begin
         idle_inputs(); is_user = 1; lvl_user[i] = 0;
         run("R1 user AND");
      end
      idle_inputs(); is_user = 1; lvl_user[L-1] = 0; lvl_valid[L-1] = 0;
      run("R1 unvisited ignored");
      idle_inputs(); nx_en = 1; lvl_xd[2] = 1;
      run("R1 xd OR exec right");
      // R2
      idle_inputs(); top_open = 1; is_user = 1; access = 2'd1;
      lvl_user[0] = 0; lvl_rw[0] = 0; lvl_xd[0] = 1; nx_en = 1;
      run("R2 top open");
      // R3
      idle_inputs(); access = 2'd2; nx_en = 1; ext_en = 1; lvl_xd[1] = 1;
      run("R3 fetch xd fault");
      idle_inputs(); access = 2'd2; nx_en = 0; lvl_xd = '1;
      run("R3 xd ignored nx off");
      // R4
      idle_inputs(); is_user = 1; access = 2'd1; lvl_rw[3] = 0;
      run("R4 user write ro");
      idle_inputs(); is_user = 1; access = 2'd0; lvl_rw[3] = 0;
      run("R4 user read ro");
      // R5
      idle_inputs(); access = 2'd1; lvl_rw[1] = 0; wp_en = 0;
      run("R5 sup write wp off");
      idle_inputs(); access = 2'd1; lvl_rw[1] = 0; wp_en = 1;
      run("R5 sup write wp on");
      // R6 / R7
      idle_inputs(); access = 2'd1; leaf_dirty = 0;
      run("R7 clean leaf no write");
      idle_inputs(); is_user = 1; lvl_rw[2] = 0;
      run("R7 user ro dirty");
      idle_inputs(); nx_en = 1;
      run("R6 read exec rights");
      // R8 / R9 / R10 / R11
      idle_inputs(); walk_fault = 2'd1; is_user = 1; access = 2'd1;
      run("R8 not present");
      idle_inputs(); walk_fault = 2'd2; access = 2'd2; nx_en = 1; ext_en = 1;
      run("R9 reserved fetch");
      idle_inputs(); access = 2'd2; nx_en = 1; ext_en = 0; lvl_xd[0] = 1;
      run("R10 fetch no ext");
      idle_inputs(); walk_fault = 2'd1;
      run("R11 walk fault wins");

      // random sweep, all requirements
      for (int k = 0; k < 600; k++) begin
         lvl_valid  = L'($urandom) | L'(1);
         lvl_user   = L'($urandom | $urandom);
         lvl_rw     = L'($urandom | $urandom);
         lvl_xd     = L'($urandom & $urandom);
         access     = 2'($urandom_range(2, 0));
         walk_fault = ($urandom_range(7, 0) == 0) ? 2'($urandom_range(2, 1)) : 2'd0;
         {is_user, wp_en, nx_en, ext_en, top_open, leaf_dirty} = 6'($urandom);
         run("R1-R12 random");
         if ($urandom_range(3, 0) == 0) begin
            @(posedge clk); #5;
            check("R12 gap idle", 11'd0);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule